// File: doc/BRIEF.md
# AES3 Channel-Status Routing Controller

This block sits between a decoded AES3 receive path and an AES3 transmit encoder and decides where the channel-status (C), user (U) and validity (V) bits sent to the encoder come from. A strap input, captured while reset is held, picks one of two policies. In pass-through policy the received C bits are stored per frame index and replayed to the encoder, U and V go out as zero, and a set of received status flags is shown on output pins. In pin-fed policy the three dual-purpose pins stop driving flags and become serial inputs for transmit C, U and V. Only the copyright and original flags stay visible.

The receiver presents one strobe per frame, with the audio word, the C bit, a block-start marker and four error bits (validity, parity, biphase, lock). Any error keeps the output audio word at its last good value. The status flags come from a completed, error-free 192-frame block. Two further straps choose the serial audio port role and its format. They are captured together with the policy strap and presented as configuration outputs.

Top module: `aes3_cs_router`

## Requirements
- R1: The values of `strap_pinfed`, `strap_master` and `strap_fmt` at the last rising clock edge with `rst_n` low appear on `cfg_pinfed`, `cfg_master` and `cfg_fmt` and stay constant until reset is asserted again. `cfg_pinfed`=1 selects pin-fed policy and 0 selects pass-through.
- R2: In pass-through policy `tx_u` and `tx_v` are always 0. At the transmit strobe for frame index k, `tx_c` takes the C bit most recently received at frame index k. After reset the stored bits are 0.
- R3: In pass-through policy `mx_pro_oe`, `mx_emph_oe` and `mx_audio_oe` are 1. `mx_pro_o` shows the professional flag. `mx_emph_o` is 1 when the 3-bit emphasis field is nonzero. `mx_audio_o` is the inverse of the non-audio flag, so it is 1 after reset.
- R4: In pin-fed policy the three output enables are 0 and `mx_pro_o`, `mx_emph_o` and `mx_audio_o` are 0. `st_copyright` and `st_original` keep updating.
- R5: In pin-fed policy, at the transmit strobe for frame index k, the block samples `mx_c_i`, `mx_u_i` and `mx_v_i` into slot k. At the same strobe, `tx_c`, `tx_u` and `tx_v` take the values stored in slot k one block earlier, or 0 after reset.
- R6: Flag positions within the block are as follows: professional = C bit of frame 0, non-audio = frame 1, copyright = frame 2, emphasis = frames 3,4,5 (frame 3 is the LSB), original = frame 15.
- R7: Flags change only at the strobe of frame 191 of a block that began with `rx_block_start`, and only if none of its 192 frames carried an error. A block with an error leaves the previous flags unchanged.
- R8: A receive strobe with any bit of `rx_err` set leaves `aud_out` unchanged.
- R9: A receive strobe with `rx_err` equal to 0 loads `rx_sample` into `aud_out` on that edge, including the first clean strobe after errors.
- R10: On both sides, a strobe that has the block-start marker set is frame index 0, and the index then advances by one on each strobe. Transmit outputs change only on transmit strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| strap_pinfed | input | 1 | Policy strap (1 = pin-fed) |
| strap_master | input | 1 | Serial port role strap |
| strap_fmt | input | 2 | Serial port format strap |
| cfg_pinfed | output | 1 | Captured policy |
| cfg_master | output | 1 | Captured port role |
| cfg_fmt | output | 2 | Captured port format |
| rx_stb | input | 1 | Received frame strobe |
| rx_block_start | input | 1 | Received frame is frame 0 |
| rx_cbit | input | 1 | Received C bit |
| rx_err | input | 4 | Validity, parity, biphase, lock error |
| rx_sample | input | SW | Received audio word |
| aud_out | output | SW | Held audio word |
| st_copyright | output | 1 | Copyright flag |
| st_original | output | 1 | Original flag |
| mx_pro_o | output | 1 | Professional flag pin drive |
| mx_pro_oe | output | 1 | Enable for that pin |
| mx_c_i | input | 1 | Same pin read as serial C |
| mx_emph_o | output | 1 | Emphasis pin drive |
| mx_emph_oe | output | 1 | Enable for that pin |
| mx_u_i | input | 1 | Same pin read as serial U |
| mx_audio_o | output | 1 | Audio pin drive |
| mx_audio_oe | output | 1 | Enable for that pin |
| mx_v_i | input | 1 | Same pin read as serial V |
| tx_stb | input | 1 | Transmit frame strobe |
| tx_block_start | input | 1 | Transmit frame is frame 0 |
| tx_c | output | 1 | C bit to encoder |
| tx_u | output | 1 | U bit to encoder |
| tx_v | output | 1 | V bit to encoder |

## Verification
The assertions assume that the straps matter only while reset is held. They also assume that each strobe is a single-cycle pulse and that the error bits and sample are valid in the same cycle as the receive strobe. The bench drives each frame as a strobe of one cycle followed by an idle cycle. It changes the straps only after reset has been released, to show that they are ignored. It never strobes the receive and transmit sides in the same cycle, so the read-before-write order of the shared C store is never exercised.

// File: rtl/aes3_cs_router.sv
module aes3_cs_router #(
  parameter int SW = 24,
  parameter int FRAMES = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_pinfed,
  input  logic          strap_master,
  input  logic [1:0]    strap_fmt,
  output logic          cfg_pinfed,
  output logic          cfg_master,
  output logic [1:0]    cfg_fmt,
  input  logic          rx_stb,
  input  logic          rx_block_start,
  input  logic          rx_cbit,
  input  logic [3:0]    rx_err,
  input  logic [SW-1:0] rx_sample,
  output logic [SW-1:0] aud_out,
  output logic          st_copyright,
  output logic          st_original,
  output logic          mx_pro_o,
  output logic          mx_pro_oe,
  input  logic          mx_c_i,
  output logic          mx_emph_o,
  output logic          mx_emph_oe,
  input  logic          mx_u_i,
  output logic          mx_audio_o,
  output logic          mx_audio_oe,
  input  logic          mx_v_i,
  input  logic          tx_stb,
  input  logic          tx_block_start,
  output logic          tx_c,
  output logic          tx_u,
  output logic          tx_v
);
  localparam int IW = $clog2(FRAMES);
  localparam logic [IW-1:0] LAST = IW'(FRAMES - 1);
  localparam int HDR = 16;

  logic          st_prof, st_nonaudio;
  logic [2:0]    st_emph;
  logic [HDR-1:0] hdr;
  logic [IW-1:0] rx_idx, tx_idx;
  logic          rx_aligned, rx_bad;
  logic [FRAMES-1:0] slot_c, slot_u, slot_v;

  always_ff @(posedge clk)
    if (!rst_n) begin
      cfg_pinfed <= strap_pinfed;
      cfg_master <= strap_master;
      cfg_fmt    <= strap_fmt;
    end

  wire [IW-1:0] rx_cur     = rx_block_start ? '0 : rx_idx;
  wire          rx_in_blk  = rx_block_start | rx_aligned;
  wire          rx_any_err = |rx_err;
  wire          rx_bad_now = (rx_bad & ~rx_block_start) | rx_any_err;
  wire          rx_commit  = rx_stb & rx_in_blk & (rx_cur == LAST) & ~rx_bad_now;
  wire [IW-1:0] tx_cur     = tx_block_start ? '0 : tx_idx;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_idx     <= '0;
      rx_aligned <= 1'b0;
      rx_bad     <= 1'b0;
      hdr        <= '0;
      aud_out    <= '0;
    end else if (rx_stb) begin
      rx_idx     <= (rx_cur == LAST) ? '0 : rx_cur + 1'b1;
      rx_aligned <= rx_in_blk & (rx_cur != LAST);
      rx_bad     <= rx_bad_now & (rx_cur != LAST);
      if (rx_cur < IW'(HDR)) hdr[rx_cur[3:0]] <= rx_cbit;
      if (!rx_any_err) aud_out <= rx_sample;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      st_prof      <= 1'b0;
      st_nonaudio  <= 1'b0;
      st_copyright <= 1'b0;
      st_emph      <= '0;
      st_original  <= 1'b0;
    end else if (rx_commit) begin
      st_prof      <= hdr[0];
      st_nonaudio  <= hdr[1];
      st_copyright <= hdr[2];
      st_emph      <= hdr[5:3];
      st_original  <= hdr[15];
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      slot_c <= '0;
      slot_u <= '0;
      slot_v <= '0;
      tx_idx <= '0;
      tx_c   <= 1'b0;
      tx_u   <= 1'b0;
      tx_v   <= 1'b0;
    end else begin
      if (!cfg_pinfed && rx_stb && rx_in_blk) slot_c[rx_cur] <= rx_cbit;
      if (tx_stb) begin
        tx_idx <= (tx_cur == LAST) ? '0 : tx_cur + 1'b1;
        tx_c   <= slot_c[tx_cur];
        tx_u   <= cfg_pinfed & slot_u[tx_cur];
        tx_v   <= cfg_pinfed & slot_v[tx_cur];
        if (cfg_pinfed) begin
          slot_c[tx_cur] <= mx_c_i;
          slot_u[tx_cur] <= mx_u_i;
          slot_v[tx_cur] <= mx_v_i;
        end
      end
    end

  assign mx_pro_oe   = ~cfg_pinfed;
  assign mx_emph_oe  = ~cfg_pinfed;
  assign mx_audio_oe = ~cfg_pinfed;
  assign mx_pro_o    = ~cfg_pinfed & st_prof;
  assign mx_emph_o   = ~cfg_pinfed & (|st_emph);
  assign mx_audio_o  = ~cfg_pinfed & ~st_nonaudio;
endmodule

// File: rtl/aes3_cs_router_chk.sv
module aes3_cs_router_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_pinfed,
  input logic          cfg_master,
  input logic [1:0]    cfg_fmt,
  input logic          rx_stb,
  input logic [3:0]    rx_err,
  input logic [SW-1:0] rx_sample,
  input logic [SW-1:0] aud_out,
  input logic          st_copyright,
  input logic          st_original,
  input logic          mx_pro_o,
  input logic          mx_pro_oe,
  input logic          mx_emph_o,
  input logic          mx_emph_oe,
  input logic          mx_audio_o,
  input logic          mx_audio_oe,
  input logic          tx_stb,
  input logic          tx_c,
  input logic          tx_u,
  input logic          tx_v
);
  logic was_run;
  always_ff @(posedge clk) was_run <= rst_n;

  a_r1_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    was_run |-> $stable({cfg_pinfed, cfg_master, cfg_fmt}));
  a_r2_uv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pinfed |-> (!tx_u && !tx_v));
  a_r3_pins_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pinfed |-> (mx_pro_oe && mx_emph_oe && mx_audio_oe));
  a_r4_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pinfed |-> (!mx_pro_oe && !mx_emph_oe && !mx_audio_oe && !mx_pro_o && !mx_emph_o && !mx_audio_o));
  a_r7_flags_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && !rx_stb) |=> $stable({st_copyright, st_original}));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && rx_stb && rx_err != 4'b0) |=> $stable(aud_out));
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rx_err == 4'b0) |=> aud_out == $past(rx_sample));
  a_r10_tx_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && !tx_stb) |=> $stable({tx_c, tx_u, tx_v}));
endmodule

bind aes3_cs_router aes3_cs_router_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pinfed(cfg_pinfed), .cfg_master(cfg_master),
  .cfg_fmt(cfg_fmt), .rx_stb(rx_stb), .rx_err(rx_err), .rx_sample(rx_sample),
  .aud_out(aud_out), .st_copyright(st_copyright), .st_original(st_original),
  .mx_pro_o(mx_pro_o), .mx_pro_oe(mx_pro_oe), .mx_emph_o(mx_emph_o),
  .mx_emph_oe(mx_emph_oe), .mx_audio_o(mx_audio_o), .mx_audio_oe(mx_audio_oe),
  .tx_stb(tx_stb), .tx_c(tx_c), .tx_u(tx_u), .tx_v(tx_v)
);

// File: tb/aes3_cs_router_tb.sv
module aes3_cs_router_tb;
  localparam int SW = 24;
  logic clk = 0, rst_n = 0;
  logic strap_pinfed = 0, strap_master = 0;
  logic [1:0] strap_fmt = 0;
  logic cfg_pinfed, cfg_master;
  logic [1:0] cfg_fmt;
  logic rx_stb = 0, rx_block_start = 0, rx_cbit = 0;
  logic [3:0] rx_err = 0;
  logic [SW-1:0] rx_sample = 0, aud_out;
  logic st_copyright, st_original;
  logic mx_pro_o, mx_pro_oe, mx_emph_o, mx_emph_oe, mx_audio_o, mx_audio_oe;
  logic mx_c_i = 0, mx_u_i = 0, mx_v_i = 0;
  logic tx_stb = 0, tx_block_start = 0, tx_c, tx_u, tx_v;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  aes3_cs_router #(.SW(SW)) u_dut (.*);

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pat1(input int i);
    case (i)
      0: return 1; 1: return 0; 2: return 1; 3: return 1; 4: return 0; 5: return 0;
      15: return 1;
      default: return (i % 7) == 3;
    endcase
  endfunction

  task automatic do_reset(input logic pf, input logic ms, input logic [1:0] fm);
    @(negedge clk);
    rst_n = 0; strap_pinfed = pf; strap_master = ms; strap_fmt = fm;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    strap_pinfed = ~pf; strap_master = ~ms; strap_fmt = ~fm;
    @(negedge clk);
  endtask

  task automatic rx_frame(input logic [SW-1:0] s, input logic c, input logic st, input logic [3:0] e);
    @(negedge clk);
    rx_stb = 1; rx_sample = s; rx_cbit = c; rx_block_start = st; rx_err = e;
    @(negedge clk);
    rx_stb = 0; rx_block_start = 0; rx_err = 0;
  endtask

  task automatic rx_block(input bit inv, input int err_at);
    for (int i = 0; i < 192; i++)
      rx_frame(SW'(i), pat1(i) ^ inv, i == 0, (i == err_at) ? 4'b0100 : 4'b0);
  endtask

  task automatic t_reset_copy;
    do_reset(0, 1, 2'b10);
    chk("R1 cfg_pinfed", cfg_pinfed, 0);
    chk("R1 cfg_master", cfg_master, 1);
    chk("R1 cfg_fmt", cfg_fmt, 2);
    chk("R2 reset tx", {tx_c, tx_u, tx_v}, 0);
    chk("R3 oe driven", {mx_pro_oe, mx_emph_oe, mx_audio_oe}, 3'b111);
    chk("R3 reset pins", {mx_pro_o, mx_emph_o, mx_audio_o}, 3'b001);
    chk("R8 reset aud", aud_out, 0);
  endtask

  task automatic t_audio_hold;
    rx_frame(24'h111111, 0, 0, 0);
    chk("R9 pass", aud_out, 24'h111111);
    for (int b = 0; b < 4; b++) begin
      rx_frame(24'h222222 + SW'(b), 0, 0, 4'(1 << b));
      chk("R8 hold per error kind", aud_out, 24'h111111);
    end
    rx_frame(24'h333333, 0, 0, 0);
    chk("R9 release immediate", aud_out, 24'h333333);
  endtask

  task automatic t_flags;
    rx_block(0, -1);
    chk("R6 R7 copyright", st_copyright, 1);
    chk("R6 R7 original", st_original, 1);
    chk("R3 R6 pins", {mx_pro_o, mx_emph_o, mx_audio_o}, 3'b111);
    rx_block(1, 100);
    chk("R7 bad block keeps flags", {st_copyright, st_original, mx_pro_o, mx_emph_o, mx_audio_o}, 5'h1f);
  endtask

  task automatic t_copy_tx;
    int bad = 0;
    for (int k = 0; k < 192; k++) begin
      @(negedge clk); tx_stb = 1; tx_block_start = (k == 0);
      @(negedge clk); tx_stb = 0; tx_block_start = 0;
      if (tx_c !== ~pat1(k) || tx_u !== 0 || tx_v !== 0) bad++;
    end
    chk("R2 R10 copied C and zero U V", bad, 0);
  endtask

  task automatic t_pinfed;
    int bad1 = 0, bad2 = 0;
    do_reset(1, 0, 2'b01);
    chk("R1 cfg pin-fed", {cfg_pinfed, cfg_master, cfg_fmt}, 4'b1001);
    chk("R4 oe released", {mx_pro_oe, mx_emph_oe, mx_audio_oe}, 0);
    for (int blk = 0; blk < 2; blk++)
      for (int k = 0; k < 192; k++) begin
        @(negedge clk);
        tx_stb = 1; tx_block_start = (k == 0);
        mx_c_i = (blk == 0) && (k % 3 == 0);
        mx_u_i = (blk == 0) && (k % 5 == 1);
        mx_v_i = (blk == 0) && (k % 2 == 1);
        @(negedge clk); tx_stb = 0; tx_block_start = 0;
        if (blk == 0 && {tx_c, tx_u, tx_v} !== 3'b000) bad1++;
        if (blk == 1 && {tx_c, tx_u, tx_v} !== {k % 3 == 0, k % 5 == 1, k % 2 == 1}) bad2++;
      end
    chk("R5 first block empty", bad1, 0);
    chk("R5 R10 one block later", bad2, 0);
    rx_block(0, -1);
    chk("R4 flags still visible", {st_copyright, st_original}, 2'b11);
    chk("R4 pins low", {mx_pro_o, mx_emph_o, mx_audio_o}, 0);
    chk("R1 straps ignored after reset", {cfg_pinfed, cfg_master, cfg_fmt}, 4'b1001);
  endtask

  initial begin
    t_reset_copy;
    t_audio_hold;
    t_flags;
    t_copy_tx;
    t_pinfed;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule